// File: doc/BRIEF.md
# Transmit Start-Threshold Controller

This block decides when a transmit MAC may begin sending the frame at the head of its transmit FIFO. Software programs a start threshold in units of four bytes through a small register port. The block compares the scaled threshold with the FIFO's byte occupancy. It raises a start request on whichever condition comes first:

- the occupancy strictly exceeds the scaled threshold;
- the FIFO reports full;
- a whole frame has been written into the FIFO.

The start request is a level. It stays high until the MAC acknowledges it. After the acknowledge the block waits for the MAC to report the end of that frame, then arms itself for the next one. No request is raised while transmission is halted. The threshold can only be changed in that halted state, and a write at any other time is dropped.

A frame-complete pulse that arrives while the block cannot act on it is remembered until the next request. This covers a pulse seen while halted or while a frame is in flight. All pins are plain control and status signals with no valid/ready handshake. The read data is combinational from the threshold register.

Top module: `tx_start_ctrl`

## Requirements
- R1: After reset the threshold register holds zero, `cfg_rdata` reads 0 and `start_req` is low.
- R2: A write with `cfg_wr` high while `tx_halted` is high loads `cfg_wdata[THR_W-1:0]` into the threshold. `cfg_rdata` then shows that value in bits THR_W-1..0, and bits 31..THR_W always read as zero.
- R3: A write while `tx_halted` is low is ignored, and `cfg_rdata` keeps its previous value.
- R4: When armed and not halted, `start_req` rises one cycle after `fifo_level` strictly exceeds four times the threshold. Occupancy equal to that product does not start transmission.
- R5: When armed and not halted, `fifo_full` high starts transmission regardless of the threshold.
- R6: A one-cycle `frame_wr_done` pulse starts transmission. A pulse that arrives while halted, or while a frame is in flight, is remembered and triggers the next start.
- R7: `start_req` never rises while `tx_halted` is high.
- R8: Once high, `start_req` stays high until a cycle with `mac_ack` high, and it is low in the cycle after that acknowledge.
- R9: After the acknowledge, no new request is raised until `frame_done` is seen. The block re-arms in the cycle after `frame_done`.
- R10: A threshold of zero lets any non-zero occupancy start transmission, and an empty FIFO does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Threshold register write strobe |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Threshold register read data |
| tx_halted | input | 1 | Transmission halted status |
| fifo_level | input | LVL_W | Bytes held in the transmit FIFO |
| fifo_full | input | 1 | Transmit FIFO full |
| frame_wr_done | input | 1 | Pulse: one whole frame written into the FIFO |
| mac_ack | input | 1 | MAC accepts the start request |
| frame_done | input | 1 | Pulse: MAC finished sending the frame |
| start_req | output | 1 | Transmit start request |

## Verification
The bench builds the block with THR_W = 4 and LVL_W = 7. This shrinks the largest threshold to 60 bytes, so the top threshold code can be exercised at the exact equal-to boundary and one byte above it. At the same width a completely full occupancy of 127 also fits. Reserved read bits are checked from bit 4 upward, which makes the masking of a write with all upper bits set visible at the port.

// File: rtl/txs_pkg.sv
package txs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_BUSY = 2'd2
  } txs_state_e;

  localparam int REG_W = 32;
endpackage

// File: rtl/txs_thr_reg.sv
module txs_thr_reg #(
  parameter int THR_W = 11
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr,
  input  logic [txs_pkg::REG_W-1:0] wdata,
  input  logic                      halted,
  output logic [THR_W-1:0]          thr,
  output logic [txs_pkg::REG_W-1:0] rdata
);
  localparam int PAD_W = txs_pkg::REG_W - THR_W;

  always_ff @(posedge clk) begin
    if (!rst_n)             thr <= '0;
    else if (wr && halted)  thr <= wdata[THR_W-1:0];
  end

  assign rdata = {{PAD_W{1'b0}}, thr};
endmodule

// File: rtl/txs_start_cond.sv
module txs_start_cond #(
  parameter int THR_W = 11,
  parameter int LVL_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [THR_W-1:0] thr,
  input  logic [LVL_W-1:0] level,
  input  logic             full,
  input  logic             frame_wr_done,
  input  logic             consume,
  output logic             cond
);
  localparam int SCL_W = THR_W + 2;
  localparam int CMP_W = (LVL_W > SCL_W) ? LVL_W : SCL_W;

  logic [SCL_W-1:0] scaled;
  logic [CMP_W-1:0] lvl_x, thr_x;
  logic             frame_seen;

  assign scaled = {thr, 2'b00};
  assign lvl_x  = CMP_W'(level);
  assign thr_x  = CMP_W'(scaled);

  always_ff @(posedge clk) begin
    if (!rst_n)       frame_seen <= 1'b0;
    else if (consume) frame_seen <= 1'b0;
    else              frame_seen <= frame_seen | frame_wr_done;
  end

  assign cond = (lvl_x > thr_x) | full | frame_wr_done | frame_seen;
endmodule

// File: rtl/txs_req_fsm.sv
module txs_req_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic cond,
  input  logic halted,
  input  logic mac_ack,
  input  logic frame_done,
  output logic go,
  output logic start_req
);
  import txs_pkg::*;

  txs_state_e st, st_n;

  assign go = (st == ST_IDLE) && !halted && cond;

  always_comb begin
    st_n = st;
    unique case (st)
      ST_IDLE: if (go)         st_n = ST_REQ;
      ST_REQ:  if (mac_ack)    st_n = ST_BUSY;
      ST_BUSY: if (frame_done) st_n = ST_IDLE;
      default:                 st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_n;
  end

  assign start_req = (st == ST_REQ);
endmodule

// File: rtl/tx_start_ctrl.sv
module tx_start_ctrl #(
  parameter int THR_W = 11,
  parameter int LVL_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  input  logic             tx_halted,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic             fifo_full,
  input  logic             frame_wr_done,
  input  logic             mac_ack,
  input  logic             frame_done,
  output logic             start_req
);
  logic [THR_W-1:0] thr;
  logic             cond, go;

  txs_thr_reg #(.THR_W(THR_W)) u_reg (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .wdata(cfg_wdata),
    .halted(tx_halted), .thr(thr), .rdata(cfg_rdata)
  );

  txs_start_cond #(.THR_W(THR_W), .LVL_W(LVL_W)) u_cond (
    .clk(clk), .rst_n(rst_n), .thr(thr), .level(fifo_level),
    .full(fifo_full), .frame_wr_done(frame_wr_done),
    .consume(go), .cond(cond)
  );

  txs_req_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .cond(cond), .halted(tx_halted),
    .mac_ack(mac_ack), .frame_done(frame_done),
    .go(go), .start_req(start_req)
  );
endmodule

// File: rtl/txs_chk.sv
module txs_chk #(
  parameter int THR_W = 11
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_wr,
  input logic [31:0] cfg_rdata,
  input logic        tx_halted,
  input logic        mac_ack,
  input logic        start_req
);
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[31:THR_W] == '0); // R2
  AST_WR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !tx_halted) |=> $stable(cfg_rdata)); // R3
  AST_NO_START_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_halted && !start_req) |=> !start_req); // R7
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && !mac_ack) |=> start_req); // R8
  AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && mac_ack) |=> !start_req); // R8
endmodule

bind tx_start_ctrl txs_chk #(.THR_W(THR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rdata(cfg_rdata),
  .tx_halted(tx_halted), .mac_ack(mac_ack), .start_req(start_req)
);

// File: tb/tx_start_ctrl_tb_top.sv
module tx_start_ctrl_tb_top;
  localparam int THR_W = 4;
  localparam int LVL_W = 7;
  localparam int NV = 8;
  // {thr[3:0], level[6:0], expect_start}
  localparam logic [11:0] VEC [NV] = '{
    {4'd0,  7'd0,   1'b0},   // R10 empty, zero threshold
    {4'd0,  7'd1,   1'b1},   // R10
    {4'd3,  7'd12,  1'b0},   // R4 equal
    {4'd3,  7'd13,  1'b1},   // R4 above
    {4'd15, 7'd60,  1'b0},   // R4 max equal
    {4'd15, 7'd61,  1'b1},   // R4
    {4'd15, 7'd127, 1'b1},   // R4
    {4'd7,  7'd20,  1'b0}    // R4 below
  };

  logic clk = 0, rst_n = 0;
  logic cfg_wr = 0, tx_halted = 1, fifo_full = 0, frame_wr_done = 0;
  logic mac_ack = 0, frame_done = 0, start_req;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic [LVL_W-1:0] fifo_level = '0;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  tx_start_ctrl #(.THR_W(THR_W), .LVL_W(LVL_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .tx_halted(tx_halted), .fifo_level(fifo_level),
    .fifo_full(fifo_full), .frame_wr_done(frame_wr_done), .mac_ack(mac_ack),
    .frame_done(frame_done), .start_req(start_req)
  );

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_thr(input logic [31:0] v);
    cfg_wr = 1; cfg_wdata = v; tick(); cfg_wr = 0;
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk); tick(); tick();
    chk("R1 req", {31'd0, start_req}, 0);
    chk("R1 rdata", cfg_rdata, 0);
    rst_n = 1; tick();
    chk("R1 idle", {31'd0, start_req}, 0);

    for (int i = 0; i < NV; i++) begin
      tx_halted = 1; tick();
      wr_thr({28'd0, VEC[i][11:8]});
      fifo_level = VEC[i][7:1]; tx_halted = 0; tick();
      chk(VEC[i][11:8] == 0 ? "R10 vec" : "R4 vec", {31'd0, start_req}, {31'd0, VEC[i][0]});
      if (start_req) begin
        mac_ack = 1; tick(); mac_ack = 0;
        frame_done = 1; tx_halted = 1; tick(); frame_done = 0;
      end
      tx_halted = 1; fifo_level = 0; tick();
    end

    // R2 write with reserved bits set
    wr_thr(32'hFFFF_FFF5);
    chk("R2", cfg_rdata, 32'h5);
    // R3 write while active ignored
    tx_halted = 0; tick();
    wr_thr(32'h9);
    chk("R3", cfg_rdata, 32'h5);
    chk("R3 req", {31'd0, start_req}, 0);

    // R7 no start while halted
    tx_halted = 1; fifo_level = 100; fifo_full = 1; tick(); tick();
    chk("R7 full", {31'd0, start_req}, 0);
    frame_wr_done = 1; tick(); frame_wr_done = 0; tick();
    chk("R7 frame", {31'd0, start_req}, 0);
    // R6 remembered frame completion starts on unhalt
    fifo_level = 0; fifo_full = 0; tx_halted = 0; tick();
    chk("R6 remembered", {31'd0, start_req}, 1);
    // R8 hold until ack
    tick(); tick();
    chk("R8 hold", {31'd0, start_req}, 1);
    mac_ack = 1; tick(); mac_ack = 0;
    chk("R8 drop", {31'd0, start_req}, 0);
    // R9 busy until frame_done
    fifo_level = 127; fifo_full = 1; tick(); tick();
    chk("R9 busy", {31'd0, start_req}, 0);
    frame_done = 1; tick(); frame_done = 0;
    chk("R9 done cycle", {31'd0, start_req}, 0);
    tick();
    chk("R9 rearm", {31'd0, start_req}, 1);
    mac_ack = 1; tick(); mac_ack = 0;
    // R6 pulse during busy remembered
    fifo_level = 0; fifo_full = 0;
    frame_wr_done = 1; tick(); frame_wr_done = 0;
    frame_done = 1; tick(); frame_done = 0; tick();
    chk("R6 busy pulse", {31'd0, start_req}, 1);
    mac_ack = 1; tick(); mac_ack = 0;
    frame_done = 1; tx_halted = 1; tick(); frame_done = 0;

    // R5 full overrides maximum threshold
    wr_thr(32'hF);
    chk("R2 max", cfg_rdata, 32'hF);
    fifo_level = 1; fifo_full = 0; tx_halted = 0; tick();
    chk("R5 not full", {31'd0, start_req}, 0);
    fifo_full = 1; tick();
    chk("R5 full", {31'd0, start_req}, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule